// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core with Split Memories

This block is a 32-bit processor core that completes one instruction in every clock cycle. It handles six instructions: register add, register subtract, word load, word store, branch-if-equal and an absolute jump. It holds a read-only instruction store, a separate data store, a 32-entry register file, an opcode decoder, an arithmetic-operation decoder and next-address logic. Each cycle the core reads the word at the program counter, decodes it, reads two registers, runs the arithmetic unit, optionally touches the data store and writes one register. All state updates happen at the same clock edge.

Both stores are filled through a load port while reset is held low. That port is how a test environment or a boot controller places the program and any starting data. Two combinational observation ports return any register and any data word, so the final machine state can be checked without disturbing execution.

Top module: `scr_core`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter becomes 0 and every register becomes 0. On the first cycle after release, pc equals 0.
- R2: The load port writes the word at load_addr into the instruction store (load_imem=1) or the data store (load_dmem=1) only while rst_n is low. While the core runs, these writes are ignored.
- R3: An instruction that is not a taken branch or a jump advances pc by 4 bytes. The instruction word is taken from index pc[IAW+1:2].
- R4: Opcode 000000 with shift field [10:6] equal to zero is a register operation. Funct [5:0]=100000 writes rs+rt into rd, and 100010 writes rs-rt into rd. rs is [25:21], rt is [20:16] and rd is [15:11].
- R5: Opcode 100011 loads the data word at byte address rs + sign-extended [15:0] into rt.
- R6: Opcode 101011 stores rt at byte address rs + sign-extended [15:0] and writes no register.
- R7: Opcode 000100 sets pc to pc+4 + (sign-extended [15:0] << 2) when rs equals rt. Otherwise pc becomes pc+4. Offsets may be negative.
- R8: Opcode 000010 sets pc to {pc+4 bits [31:28], [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and a write that targets it has no effect.
- R10: Any other opcode, or a register operation with another funct or a nonzero shift field, writes no register and no data word, and the core moves on to pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also opens the load port |
| load_imem | input | 1 | Write load_data into the instruction store (reset only) |
| load_dmem | input | 1 | Write load_data into the data store (reset only) |
| load_addr | input | LAW | Word index for the load port |
| load_data | input | 32 | Word to load |
| pc | output | 32 | Current program counter (byte address) |
| obs_reg_sel | input | 5 | Register number to observe |
| obs_reg_val | output | 32 | Combinational value of the selected register |
| obs_mem_addr | input | DAW | Data word index to observe |
| obs_mem_val | output | 32 | Combinational value of the selected data word |

## Verification
The bench builds the core with its default sizes of 64 instruction words and 64 data words, so the load port and both stores use 6-bit word indices. That space holds a 19-word program covering a forward taken branch, a not-taken branch, a backward branch used as the final halt loop, a jump that skips code, a load with a negative offset, a store followed by a load of the same word, a write aimed at register 0, and an undefined opcode. The jump's upper address bits are always zero at this size, so only the low 26-bit field of the target is exercised.

// File: rtl/scr_pkg.sv
// Shared encodings for the single-cycle core: opcodes, funct codes,
// arithmetic operation selector and the control word from the decoder.
package scr_pkg;
    localparam logic [5:0] OP_REG  = 6'b000000;
    localparam logic [5:0] OP_LOAD = 6'b100011;
    localparam logic [5:0] OP_STOR = 6'b101011;
    localparam logic [5:0] OP_BEQ  = 6'b000100;
    localparam logic [5:0] OP_JMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;

    typedef enum logic [2:0] {
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110
    } alu_op_e;

    typedef struct packed {
        logic dst_rd;   // write target is rd (else rt)
        logic src_imm;  // second operand is the sign-extended immediate
        logic wb_mem;   // write-back value comes from the data store
        logic reg_we;   // register file write enable
        logic mem_rd;   // data store read enable
        logic mem_we;   // data store write enable
        logic branch;   // conditional branch on equality
        logic jump;     // absolute jump
    } ctrl_t;
endpackage

// File: rtl/scr_decode.sv
// Main control and arithmetic-operation decoder.
// Assumes: the instruction word is valid for the current cycle; anything
// outside the supported set decodes to an all-zero (no effect) control word.
module scr_decode
    import scr_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] funct_i,
    input  logic [4:0] shamt_i,
    output ctrl_t      ctl_o,
    output alu_op_e    alu_o
);
    // Decode opcode (and funct for register ops) into control lines.
    always_comb begin
        ctl_o = '0;
        alu_o = ALU_ADD;
        case (op_i)
            OP_REG: begin
                ctl_o.dst_rd = 1'b1;
                ctl_o.reg_we = (shamt_i == 5'd0) &&
                               ((funct_i == FN_ADD) || (funct_i == FN_SUB));
                alu_o        = (funct_i == FN_SUB) ? ALU_SUB : ALU_ADD;
            end
            OP_LOAD: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.wb_mem  = 1'b1;
                ctl_o.reg_we  = 1'b1;
                ctl_o.mem_rd  = 1'b1;
            end
            OP_STOR: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl_o.branch = 1'b1;
                alu_o        = ALU_SUB;
            end
            OP_JMP: begin
                ctl_o.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scr_regfile.sv
// Register file: two read ports, one observation read port, one write port.
// Assumes: entry 0 is hardwired to zero; reset clears every entry.
module scr_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_obs,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_obs,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise write one entry other than 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Combinational reads with entry 0 forced to zero.
    always_comb begin
        rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
        rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
        rd_obs = (ra_obs == '0) ? '0 : regs[ra_obs];
    end
endmodule

// File: rtl/scr_alu.sv
// Arithmetic unit for the core: add or subtract, plus an equality flag.
// Assumes: the decoder only selects the operations in alu_op_e.
module scr_alu
    import scr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    // Select the result and flag an all-zero outcome.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/scr_core.sv
// Single-cycle core top: instruction store, data store, next-address logic.
// Assumes: the stores are filled through the load port while rst_n is low;
// word-aligned accesses only, addresses wrap within each store's depth.
module scr_core
    import scr_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_imem,
    input  logic           load_dmem,
    input  logic [LAW-1:0] load_addr,
    input  logic [31:0]    load_data,
    output logic [31:0]    pc,
    input  logic [4:0]     obs_reg_sel,
    output logic [31:0]    obs_reg_val,
    input  logic [DAW-1:0] obs_mem_addr,
    output logic [31:0]    obs_mem_val
);
    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0]    instr;
    ctrl_t          ctl;
    alu_op_e        alu_op;
    logic [31:0]    rs_val, rt_val, alu_b, alu_y, imm_sx;
    logic           alu_zero;
    logic [31:0]    mem_rdata, wb_data;
    logic [4:0]     wa;
    logic [DAW-1:0] d_idx;
    logic [31:0]    pc_seq, pc_br, pc_jmp, pc_next;
    logic           rf_we, dm_we;

    // Fetch the instruction word at the program counter.
    assign instr  = imem[pc[IAW+1:2]];
    assign imm_sx = {{16{instr[15]}}, instr[15:0]};

    scr_decode u_dec (
        .op_i    (instr[31:26]),
        .funct_i (instr[5:0]),
        .shamt_i (instr[10:6]),
        .ctl_o   (ctl),
        .alu_o   (alu_op)
    );

    assign rf_we = ctl.reg_we;
    assign dm_we = ctl.mem_we;
    assign wa    = ctl.dst_rd ? instr[15:11] : instr[20:16];

    scr_regfile #(.NREG(32), .W(32)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (instr[25:21]),
        .ra_b   (instr[20:16]),
        .ra_obs (obs_reg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_obs (obs_reg_val),
        .we     (rf_we),
        .wa     (wa),
        .wd     (wb_data)
    );

    assign alu_b = ctl.src_imm ? imm_sx : rt_val;

    scr_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Instruction store: written only through the load port during reset.
    always_ff @(posedge clk) begin
        if (!rst_n && load_imem) imem[load_addr[IAW-1:0]] <= load_data;
    end

    // Data store: load port during reset, store instructions while running.
    assign d_idx = alu_y[DAW+1:2];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (load_dmem) dmem[load_addr[DAW-1:0]] <= load_data;
        end else if (ctl.mem_we) begin
            dmem[d_idx] <= rt_val;
        end
    end

    // Read path for loads and for observation.
    assign mem_rdata   = ctl.mem_rd ? dmem[d_idx] : '0;
    assign obs_mem_val = dmem[obs_mem_addr];
    assign wb_data     = ctl.wb_mem ? mem_rdata : alu_y;

    // Next-address candidates and selection.
    always_comb begin
        pc_seq = pc + 32'd4;
        pc_br  = pc_seq + {imm_sx[29:0], 2'b00};
        pc_jmp = {pc_seq[31:28], instr[25:0], 2'b00};
        if (ctl.jump)                  pc_next = pc_jmp;
        else if (ctl.branch && alu_zero) pc_next = pc_br;
        else                           pc_next = pc_seq;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end
endmodule

// File: rtl/scr_core_chk.sv
// Property checker for scr_core, attached through bind.
// Assumes: it sees the fetched word and the decoder's write enables.
module scr_core_chk
    import scr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input logic [4:0]  obs_reg_sel,
    input logic [31:0] obs_reg_val
);
    logic [5:0]  op;
    logic [31:0] seq;
    logic        known;
    assign op    = instr[31:26];
    assign seq   = pc + 32'd4;
    assign known = (op == OP_REG) || (op == OP_LOAD) || (op == OP_STOR) ||
                   (op == OP_BEQ) || (op == OP_JMP);

    AST_PC_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == 32'd0)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_REG) || (op == OP_LOAD) || (op == OP_STOR)) |=>
        (pc == $past(pc) + 32'd4)); // R3

    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STOR) |-> (dm_we && !rf_we)); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JMP) |=>
        (pc == {$past(seq[31:28]), $past(instr[25:0]), 2'b00})); // R8

    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_reg_sel == 5'd0) |-> (obs_reg_val == 32'd0)); // R9

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (!rf_we && !dm_we)); // R10

    AST_UNDEF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !known |=> (pc == $past(pc) + 32'd4)); // R10
endmodule

bind scr_core scr_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc          (pc),
    .instr       (instr),
    .rf_we       (rf_we),
    .dm_we       (dm_we),
    .obs_reg_sel (obs_reg_sel),
    .obs_reg_val (obs_reg_val)
);

// File: tb/scr_core_bench.sv
`timescale 1ns/1ps
module scr_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_imem = 1'b0;
    logic        load_dmem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc;
    logic [4:0]  obs_reg_sel = '0;
    logic [31:0] obs_reg_val;
    logic [5:0]  obs_mem_addr = '0;
    logic [31:0] obs_mem_val;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scr_core u_scr_core (
        .clk(clk), .rst_n(rst_n), .load_imem(load_imem), .load_dmem(load_dmem),
        .load_addr(load_addr), .load_data(load_data), .pc(pc),
        .obs_reg_sel(obs_reg_sel), .obs_reg_val(obs_reg_val),
        .obs_mem_addr(obs_mem_addr), .obs_mem_val(obs_mem_val)
    );

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_j(logic [25:0] idx);
        return {6'b000010, idx};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reg(string req, int r, logic [31:0] exp);
        @(negedge clk);
        obs_reg_sel = 5'(r);
        #1;
        check(req, obs_reg_val, exp);
    endtask

    task automatic check_mem(string req, int a, logic [31:0] exp);
        @(negedge clk);
        obs_mem_addr = 6'(a);
        #1;
        check(req, obs_mem_val, exp);
    endtask

    task automatic steps_then_pc(string req, int n, logic [31:0] exp);
        repeat (n) @(posedge clk);
        @(negedge clk);
        check(req, pc, exp);
    endtask

    // R1: reset clears pc and all registers.
    task automatic t_reset_state();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc in reset", pc, 32'd0);
        for (int r = 0; r < 32; r++) check_reg("R1 reg cleared", r, 32'd0);
    endtask

    // R2: load the program and data while reset is low.
    task automatic t_load();
        logic [31:0] prog [19];
        prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
        prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(2, 1, 4, 6'h22);
        prog[4]  = enc_i(6'h2B, 0, 3, 16'd8);
        prog[5]  = enc_i(6'h04, 1, 2, 16'd5);
        prog[6]  = enc_r(1, 2, 5, 6'h22);
        prog[7]  = enc_r(1, 2, 0, 6'h20);
        prog[8]  = enc_i(6'h04, 1, 1, 16'd2);
        prog[9]  = enc_r(1, 1, 6, 6'h20);
        prog[10] = enc_i(6'h2B, 0, 1, 16'd16);
        prog[11] = enc_i(6'h23, 0, 7, 16'd8);
        prog[12] = enc_i(6'h23, 3, 8, 16'hFFF8);
        prog[13] = enc_i(6'h2B, 0, 5, 16'd12);
        prog[14] = {6'h3F, 5'd0, 5'd9, 16'd0};
        prog[15] = enc_j(26'd18);
        prog[16] = enc_r(1, 1, 10, 6'h20);
        prog[17] = enc_r(1, 1, 11, 6'h20);
        prog[18] = enc_i(6'h04, 0, 0, 16'hFFFF);
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            load_imem = 1'b1; load_addr = 6'(i); load_data = prog[i];
        end
        @(negedge clk);
        load_imem = 1'b0; load_dmem = 1'b1; load_addr = 6'd0; load_data = 32'd5;
        @(negedge clk);
        load_addr = 6'd1; load_data = 32'd7;
        @(negedge clk);
        load_addr = 6'd4; load_data = 32'h0000_00AA;
        @(negedge clk);
        load_dmem = 1'b0;
        check_mem("R2 data loaded in reset", 1, 32'd7);
    endtask

    // R3/R7/R8: follow the program counter through the program.
    task automatic t_run();
        @(negedge clk);
        rst_n = 1'b1;
        steps_then_pc("R3 first step", 1, 32'd4);
        steps_then_pc("R7 not-taken beq", 5, 32'd24);
        steps_then_pc("R3 sequential", 2, 32'd32);
        steps_then_pc("R7 taken forward beq", 1, 32'd44);
        steps_then_pc("R10 undefined advances", 4, 32'd60);
        steps_then_pc("R8 jump target", 1, 32'd72);
        steps_then_pc("R7 backward beq halt", 1, 32'd72);
        steps_then_pc("R7 halt holds", 3, 32'd72);
    endtask

    // R4/R5/R6/R9/R10: final register and data contents.
    task automatic t_state();
        check_reg("R5 load r1", 1, 32'd5);
        check_reg("R5 load r2", 2, 32'd7);
        check_reg("R4 add r3", 3, 32'd12);
        check_reg("R4 sub r4", 4, 32'd2);
        check_reg("R4 sub negative r5", 5, 32'hFFFF_FFFE);
        check_reg("R9 r0 write ignored", 0, 32'd0);
        check_reg("R7 skipped r6", 6, 32'd0);
        check_reg("R5 load after store r7", 7, 32'd12);
        check_reg("R5 negative offset r8", 8, 32'd7);
        check_reg("R10 undefined no write r9", 9, 32'd0);
        check_reg("R8 jump skipped r10", 10, 32'd0);
        check_reg("R8 jump skipped r11", 11, 32'd0);
        check_mem("R6 store word2", 2, 32'd12);
        check_mem("R6 store word3", 3, 32'hFFFF_FFFE);
        check_mem("R7 skipped store word4", 4, 32'h0000_00AA);
        check_mem("R10 undefined no store word0", 0, 32'd5);
    endtask

    // R2: load port is ignored while running.
    task automatic t_load_ignored();
        @(negedge clk);
        load_dmem = 1'b1; load_addr = 6'd0; load_data = 32'd99;
        @(negedge clk);
        load_dmem = 1'b0; load_imem = 1'b1; load_addr = 6'd18;
        load_data = enc_r(1, 1, 12, 6'h20);
        @(negedge clk);
        load_imem = 1'b0;
        repeat (3) @(posedge clk);
        check_mem("R2 data load ignored", 0, 32'd5);
        check_reg("R2 imem load ignored", 12, 32'd0);
        check("R2 pc unchanged", pc, 32'd72);
    endtask

    initial begin
        t_reset_state();
        t_load();
        t_run();
        t_state();
        t_load_ignored();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule